// File: doc/BRIEF.md
# Dual-Direction Hold/Pass Bus Transceiver

This block connects two data ports, A and B, with one independent path in each direction. Each path holds one storage word that can work in four ways. It can pass data straight through, like an open latch. It can hold a word while its strobe is static. It can capture the input on each falling strobe edge. It can also capture on falling edges only while a separate strobe enable is asserted. Each output is modelled as a tri-state bus: a data vector plus an enable, driven or released by that direction's active-low drive control.

All storage runs in the `clk` domain. The direction strobes (`ab_stb_n`, `ba_stb_n`) are sampled on `clk`. A falling strobe edge is a sample of 0 that follows a sample of 1.

Each path is governed by a three-state FSM. The states are:
- `LANE_PASS`: pass is high.
- `LANE_HOLD_HI`: pass is low and the last strobe sample was high.
- `LANE_HOLD_LO`: pass is low and the last strobe sample was low.

The transitions are:
- `PASS_ENTER`: pass high, from any state, to `LANE_PASS`.
- `STB_SEEN_HI`: pass low with the strobe high, from any state, to `LANE_HOLD_HI`.
- `STB_SEEN_LO`: pass low with the strobe low, from any state, to `LANE_HOLD_LO`.

A capture happens only on `STB_SEEN_LO` taken from `LANE_HOLD_HI`, and only with the strobe enable low. Reset places each FSM in `LANE_HOLD_LO`.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a direction's pass input is 1, its far-side output data equals its near-side input in the same cycle, combinationally, and the storage loads that input at every `clk` edge.
- R2: With pass at 0 and the strobe level unchanged between consecutive `clk` samples, the output data does not change.
- R3: With pass at 0 and strobe enable at 0, a strobe sample of 0 that follows a sample of 1 loads the input present at that `clk` edge. The new value is visible right after that edge.
- R4: With the strobe enable at 1, a falling strobe edge leaves the stored word unchanged.
- R5: When pass goes from 1 to 0, the stored word is the input sampled at the last `clk` edge while pass was 1.
- R6: Drive control at 0 sets the output enable to 1 (bus driven). Drive control at 1 sets it to 0, and the bus is high impedance. The drive control never alters the stored word.
- R7: The B-to-A path behaves identically, using its own pass, strobe, strobe enable and drive inputs. Neither path's inputs affect the other path's output.
- R8: Synchronous reset clears both stored words to zero and puts both FSMs in `LANE_HOLD_LO`, so a strobe already low when reset is released does not count as a falling edge.
- R9: A rising strobe edge never loads data.
- R10: The data width is the parameter `W`, default 18, and both directions use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all storage |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Data arriving from the A bus |
| b_in | input | W | Data arriving from the B bus |
| ab_pass | input | 1 | A-to-B pass (transparent) select |
| ab_stb_n | input | 1 | A-to-B strobe; falling edge captures |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_drv_n | input | 1 | B output drive control, active low |
| ba_pass | input | 1 | B-to-A pass (transparent) select |
| ba_stb_n | input | 1 | B-to-A strobe; falling edge captures |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_drv_n | input | 1 | A output drive control, active low |
| a_out | output | W | Data toward the A bus |
| a_oe | output | 1 | A bus driven when 1 |
| b_out | output | W | Data toward the B bus |
| b_oe | output | 1 | B bus driven when 1 |

## Verification
One stimulus table is run on each direction in turn.

- It steps the strobe through static high, static low, rising and falling levels with the enable both asserted and released. This separates a true falling-edge capture from a rising edge, a static level and a gated edge.
- Pass phases end with a distinct final word, which separates "keeps the last passed value" from "keeps an older capture".
- Drive-control steps observe the modelled bus for Z and then re-enable it to confirm the word survived.
- Directed tests cover combinational pass-through between clock edges, a strobe already low at reset release, and whether the idle direction stays untouched.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int unsigned NUM_DIR = 2;
    localparam int unsigned DIR_AB  = 0;
    localparam int unsigned DIR_BA  = 1;

    typedef enum logic [1:0] {
        LANE_PASS    = 2'd0,
        LANE_HOLD_HI = 2'd1,
        LANE_HOLD_LO = 2'd2
    } lane_state_e;

endpackage

// File: rtl/xcvr_hold_lane.sv
module xcvr_hold_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic         stb_n,
    input  logic         stb_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] store
);

    lane_state_e state_q;
    lane_state_e state_d;
    logic        load;

    // State register: tracks pass mode and the last sampled strobe level.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LANE_HOLD_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and load decision.
    always_comb begin
        load    = 1'b0;
        state_d = state_q;
        if (pass) begin
            state_d = LANE_PASS;
            load    = 1'b1;
        end else begin
            unique case (state_q)
                LANE_PASS: begin
                    state_d = stb_n ? LANE_HOLD_HI : LANE_HOLD_LO;
                end
                LANE_HOLD_HI: begin
                    if (!stb_n) begin
                        state_d = LANE_HOLD_LO;
                        load    = !stb_en_n;
                    end
                end
                LANE_HOLD_LO: begin
                    if (stb_n) begin
                        state_d = LANE_HOLD_HI;
                    end
                end
                default: begin
                    state_d = LANE_HOLD_LO;
                end
            endcase
        end
    end

    // Storage word.
    always_ff @(posedge clk) begin
        if (rst) begin
            store <= '0;
        end else if (load) begin
            store <= din;
        end
    end

endmodule

// File: rtl/xcvr_drive_stage.sv
module xcvr_drive_stage #(
    parameter int unsigned W = 18
) (
    input  logic         pass,
    input  logic         drv_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] store,
    output logic [W-1:0] dout,
    output logic         oe
);

    always_comb begin
        dout = pass ? din : store;
        oe   = !drv_n;
    end

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_pass,
    input  logic         ab_stb_n,
    input  logic         ab_stb_en_n,
    input  logic         ab_drv_n,
    input  logic         ba_pass,
    input  logic         ba_stb_n,
    input  logic         ba_stb_en_n,
    input  logic         ba_drv_n,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] src_d   [NUM_DIR];
    logic [W-1:0] store_q [NUM_DIR];
    logic [W-1:0] far_d   [NUM_DIR];
    logic         far_oe  [NUM_DIR];
    logic         pass_v  [NUM_DIR];
    logic         stb_v   [NUM_DIR];
    logic         en_v    [NUM_DIR];
    logic         drv_v   [NUM_DIR];

    always_comb begin
        src_d[DIR_AB]  = a_in;
        src_d[DIR_BA]  = b_in;
        pass_v[DIR_AB] = ab_pass;
        pass_v[DIR_BA] = ba_pass;
        stb_v[DIR_AB]  = ab_stb_n;
        stb_v[DIR_BA]  = ba_stb_n;
        en_v[DIR_AB]   = ab_stb_en_n;
        en_v[DIR_BA]   = ba_stb_en_n;
        drv_v[DIR_AB]  = ab_drv_n;
        drv_v[DIR_BA]  = ba_drv_n;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xcvr_hold_lane #(.W(W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .pass     (pass_v[d]),
            .stb_n    (stb_v[d]),
            .stb_en_n (en_v[d]),
            .din      (src_d[d]),
            .store    (store_q[d])
        );

        xcvr_drive_stage #(.W(W)) u_drive (
            .pass  (pass_v[d]),
            .drv_n (drv_v[d]),
            .din   (src_d[d]),
            .store (store_q[d]),
            .dout  (far_d[d]),
            .oe    (far_oe[d])
        );
    end

    always_comb begin
        b_out = far_d[DIR_AB];
        b_oe  = far_oe[DIR_AB];
        a_out = far_d[DIR_BA];
        a_oe  = far_oe[DIR_BA];
    end

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
    parameter int unsigned W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_pass,
    input logic         ab_stb_n,
    input logic         ab_stb_en_n,
    input logic         ab_drv_n,
    input logic         ba_pass,
    input logic         ba_stb_n,
    input logic         ba_stb_en_n,
    input logic         ba_drv_n,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    AST_AB_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ab_pass |-> (b_out == a_in)); // R1

    AST_AB_STATIC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && $past(!ab_pass) && ($past(ab_stb_n) == $past(ab_stb_n, 2))
         && !$past(rst) && !$past(rst, 2)) |-> (b_out == $past(b_out))); // R2

    AST_AB_FALL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && $past(!ab_pass) && !$past(ab_stb_n) && $past(ab_stb_n, 2)
         && !$past(ab_stb_en_n) && !$past(rst) && !$past(rst, 2))
        |-> (b_out == $past(a_in))); // R3

    AST_AB_GATED_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && $past(!ab_pass) && $past(ab_stb_en_n) && !$past(rst))
        |-> (b_out == $past(b_out))); // R4

    AST_AB_PASS_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!ab_pass && $past(ab_pass) && !$past(rst)) |-> (b_out == $past(a_in))); // R5

    AST_AB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ab_drv_n |-> !b_oe); // R6

    AST_AB_CLEARED: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !ab_pass) |-> (b_out == '0)); // R8

    AST_BA_PASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ba_pass |-> (a_out == b_in)); // R7

    AST_BA_STATIC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && $past(!ba_pass) && ($past(ba_stb_n) == $past(ba_stb_n, 2))
         && !$past(rst) && !$past(rst, 2)) |-> (a_out == $past(a_out))); // R7

    AST_BA_FALL_LOADS: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && $past(!ba_pass) && !$past(ba_stb_n) && $past(ba_stb_n, 2)
         && !$past(ba_stb_en_n) && !$past(rst) && !$past(rst, 2))
        |-> (a_out == $past(b_in))); // R7

    AST_BA_GATED_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!ba_pass && $past(!ba_pass) && $past(ba_stb_en_n) && !$past(rst))
        |-> (a_out == $past(a_out))); // R7

    AST_BA_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ba_drv_n |-> !a_oe); // R7

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_in        (a_in),
    .b_in        (b_in),
    .ab_pass     (ab_pass),
    .ab_stb_n    (ab_stb_n),
    .ab_stb_en_n (ab_stb_en_n),
    .ab_drv_n    (ab_drv_n),
    .ba_pass     (ba_pass),
    .ba_stb_n    (ba_stb_n),
    .ba_stb_en_n (ba_stb_en_n),
    .ba_drv_n    (ba_drv_n),
    .a_out       (a_out),
    .a_oe        (a_oe),
    .b_out       (b_out),
    .b_oe        (b_oe)
);

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;

    localparam int unsigned W  = 18;
    localparam int unsigned NV = 13;

    // Entry: {pass, stb_n, stb_en_n, drv_n, din[17:0], expected[17:0], expect_z}
    localparam logic [40:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h01111, 18'h00000, 1'b0}, // R2 high level seen, no load
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h02222, 18'h02222, 1'b0}, // R3 falling edge
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h03333, 18'h02222, 1'b0}, // R2 static low
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h04444, 18'h02222, 1'b0}, // R9 rising edge
        {1'b0, 1'b0, 1'b1, 1'b0, 18'h05555, 18'h02222, 1'b0}, // R4 gated fall
        {1'b0, 1'b1, 1'b1, 1'b0, 18'h06666, 18'h02222, 1'b0}, // R9
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h07777, 18'h07777, 1'b0}, // R3
        {1'b1, 1'b0, 1'b0, 1'b0, 18'h0ABCD, 18'h0ABCD, 1'b0}, // R1
        {1'b1, 1'b1, 1'b0, 1'b1, 18'h15A5A, 18'h15A5A, 1'b1}, // R6 released
        {1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h15A5A, 1'b0}, // R5
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h00F0F, 1'b0}, // R3
        {1'b0, 1'b0, 1'b0, 1'b1, 18'h12345, 18'h00F0F, 1'b1}, // R6 released
        {1'b0, 1'b0, 1'b0, 1'b0, 18'h00000, 18'h00F0F, 1'b0}  // R6 word kept
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         ab_pass = 1'b0, ab_stb_n = 1'b1, ab_stb_en_n = 1'b0, ab_drv_n = 1'b0;
    logic         ba_pass = 1'b0, ba_stb_n = 1'b1, ba_stb_en_n = 1'b0, ba_drv_n = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    wire  [W-1:0] a_bus = a_oe ? a_out : {W{1'bz}};
    wire  [W-1:0] b_bus = b_oe ? b_out : {W{1'bz}};

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    dual_path_xcvr #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_pass(ab_pass), .ab_stb_n(ab_stb_n), .ab_stb_en_n(ab_stb_en_n), .ab_drv_n(ab_drv_n),
        .ba_pass(ba_pass), .ba_stb_n(ba_stb_n), .ba_stb_en_n(ba_stb_en_n), .ba_drv_n(ba_drv_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_dir(input int dir, input logic p, input logic s,
                             input logic e, input logic dv, input logic [W-1:0] d);
        if (dir == 0) begin
            ab_pass = p; ab_stb_n = s; ab_stb_en_n = e; ab_drv_n = dv; a_in = d;
        end else begin
            ba_pass = p; ba_stb_n = s; ba_stb_en_n = e; ba_drv_n = dv; b_in = d;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive_dir(0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        drive_dir(1, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_table(input int dir);
        for (int i = 0; i < NV; i++) begin
            logic [40:0]  v;
            logic [W-1:0] far;
            logic [W-1:0] other;
            v = VEC[i];
            @(negedge clk);
            drive_dir(dir, v[40], v[39], v[38], v[37], v[36:19]);
            @(posedge clk);
            #1;
            far   = (dir == 0) ? b_bus : a_bus;
            other = (dir == 0) ? a_bus : b_bus;
            if (v[0]) begin
                check($sformatf("R6 dir%0d step%0d bus Z", dir, i), far, {W{1'bz}});
            end else begin
                check($sformatf("R1-R5/R9 dir%0d step%0d (R7 when dir1)", dir, i), far, v[18:1]);
            end
            check($sformatf("R7 dir%0d step%0d idle path", dir, i), other, '0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: width
        n_cmp++;
        if ($bits(b_out) != 18) begin
            n_bad++;
            $display("FAIL R10 actual=%0d expected=18", $bits(b_out));
        end

        // R8: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 b_out after reset", b_bus, '0);
        check("R8 a_out after reset", a_bus, '0);

        run_table(0);
        do_reset();
        check("R8 storage cleared A->B", b_bus, '0);
        run_table(1);

        // R8: strobe already low at reset release is not an edge
        @(negedge clk);
        rst = 1'b1;
        ab_stb_n = 1'b0;
        ab_pass = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        a_in = 18'h2AAAA;
        @(posedge clk); #1;
        check("R8 low strobe at release no load", b_bus, '0);
        @(negedge clk); ab_stb_n = 1'b1;
        @(negedge clk); ab_stb_n = 1'b0;
        @(posedge clk); #1;
        check("R3 load after fresh edge", b_bus, 18'h2AAAA);

        // R1: combinational pass between edges
        @(negedge clk);
        ab_pass = 1'b1;
        a_in = 18'h11111;
        #1;
        check("R1 pass same cycle", b_bus, 18'h11111);
        a_in = 18'h22222;
        #1;
        check("R1 pass follows change", b_bus, 18'h22222);

        // R7: B-to-A pass combinational
        ba_pass = 1'b1;
        b_in = 18'h3C3C3;
        #1;
        check("R7 B-to-A pass", a_bus, 18'h3C3C3);
        check("R7 A-to-B unaffected", b_bus, 18'h22222);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule